// File: doc/BRIEF.md
# Split-Capable Auto-Reload Timer

The block is a count-up timer with automatic reload. It runs either as one 16-bit counter or as two 8-bit counters that do not depend on each other. A narrow register port gives software access to five locations: a control/status byte, a reload byte for each half and a count byte for each half. Every overflow puts the matching reload value back into the counter in the same count step. The count therefore never passes through zero, and the overflow period is set entirely by the reload value.

A count step comes from one of two sources. The first is a divide-by-12 prescaler on the system clock. The second is a divide-by-8 prescaler fed by rising edges of an external clock, after that clock has been synchronized. A control bit chooses which of the two is the base tick. Each byte also has its own select input that can replace the base tick with a step on every system clock cycle. Overflow flags are sticky. An interrupt request combines these flags with an enable that arrives from outside the block.

Top module: `split_reload_timer`

## Requirements
- R1: After synchronous reset, all five register locations read 0x00 and `irq` is low. The locations are 0 control, 1 low reload, 2 high reload, 3 low count and 4 high count.
- R2: The control byte has these bits: bit 7 high overflow flag, bit 6 low overflow flag, bit 5 low-overflow interrupt enable, bit 3 split mode, bit 2 run, bit 0 external tick select. Bits 4 and 1 always read 0, and writes to them are ignored.
- R3: In 16-bit mode (split=0), a step taken at count 0xFFFF loads {high reload, low reload} and sets both overflow flags.
- R4: In 16-bit mode, a step taken at low byte 0xFF with the high byte not at 0xFF gives low byte 0x00 and high byte +1, and sets only the low overflow flag.
- R5: In split mode the low byte steps on every low-byte tick whatever the run bit is. A step taken at 0xFF loads the low reload and sets the low overflow flag.
- R6: In split mode the high byte steps only while run=1. A step taken at 0xFF loads the high reload and sets the high overflow flag. The low flag is not touched.
- R7: In 16-bit mode with run=0, neither count byte changes.
- R8: Hardware never clears an overflow flag; only a control write does. If a hardware set and a control write clearing the same flag fall in one cycle, the flag ends up set.
- R9: `irq` = `irq_enable` AND (high flag OR (low interrupt enable AND low flag)).
- R10: With a byte's fast select low, that byte steps on the base tick. The base tick is one in 12 system cycles when bit 0 is 0, and one per 8 synchronized external rising edges when bit 0 is 1. In 16-bit mode both bytes follow the low byte's selection.
- R11: A write to a count byte in a cycle that also has a step stores the written value, and no step is applied to that byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_clk | input | 1 | External clock, asynchronous to clk |
| lo_fast | input | 1 | Low byte steps every system cycle when 1, on the base tick when 0 |
| hi_fast | input | 1 | Same choice as lo_fast, for the high byte in split mode |
| irq_enable | input | 1 | Timer interrupt enable from the interrupt controller |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register location, 0 to 4 |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Two events can land on the same clock edge: the hardware setting of an overflow flag and a software control write that clears it. The bench arranges this with a split-mode low byte that steps every cycle. It loads that byte with 0xFE and issues the control write two edges later. Reading 0x48 back shows that the flag survived the clearing write. A second collision is a count write in a cycle that also has a step. This is judged by reading the written value back unchanged and then seeing it increment once on the following edge.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [2:0] {
        A_CTRL   = 3'd0,
        A_RLD_LO = 3'd1,
        A_RLD_HI = 3'd2,
        A_CNT_LO = 3'd3,
        A_CNT_HI = 3'd4
    } reg_addr_e;

    typedef struct packed {
        logic ovf_hi;
        logic ovf_lo;
        logic lo_irq_en;
        logic split;
        logic run;
        logic ext_sel;
    } ctrl_t;

    typedef struct packed {
        logic lo_wrap;
        logic hi_wrap;
    } wrap_t;

    function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
        return {c.ovf_hi, c.ovf_lo, c.lo_irq_en, 1'b0, c.split, c.run, 1'b0, c.ext_sel};
    endfunction

    function automatic ctrl_t byte_to_ctrl(logic [7:0] d);
        ctrl_t c;
        c.ovf_hi    = d[7];
        c.ovf_lo    = d[6];
        c.lo_irq_en = d[5];
        c.split     = d[3];
        c.run       = d[2];
        c.ext_sel   = d[0];
        return c;
    endfunction

endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
    parameter int unsigned SYS_DIV  = 12,
    parameter int unsigned EXT_DIV  = 8,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ext_clk,
    output logic tick_sys,
    output logic tick_ext
);
    localparam int unsigned SW = (SYS_DIV > 1) ? $clog2(SYS_DIV) : 1;
    localparam int unsigned EW = (EXT_DIV > 1) ? $clog2(EXT_DIV) : 1;
    localparam logic [SW-1:0] SYS_LAST = SW'(SYS_DIV - 1);
    localparam logic [EW-1:0] EXT_LAST = EW'(EXT_DIV - 1);

    logic [SW-1:0] sys_cnt;
    logic [EW-1:0] ext_cnt;
    logic          sync_out;
    logic          ext_prev;
    logic          ext_rise;

    always_ff @(posedge clk) begin
        if (rst)                  sys_cnt <= '0;
        else if (sys_cnt == SYS_LAST) sys_cnt <= '0;
        else                      sys_cnt <= sys_cnt + SW'(1);
    end

    assign tick_sys = (sys_cnt == SYS_LAST);

    generate
        if (SYNC_LEN > 1) begin : g_sync_chain
            logic [SYNC_LEN-1:0] chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[SYNC_LEN-2:0], ext_clk};
            end
            assign sync_out = chain[SYNC_LEN-1];
        end else begin : g_sync_single
            logic chain;
            always_ff @(posedge clk) begin
                if (rst) chain <= 1'b0;
                else     chain <= ext_clk;
            end
            assign sync_out = chain;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) ext_prev <= 1'b0;
        else     ext_prev <= sync_out;
    end

    assign ext_rise = sync_out && !ext_prev;

    always_ff @(posedge clk) begin
        if (rst) ext_cnt <= '0;
        else if (ext_rise) begin
            if (ext_cnt == EXT_LAST) ext_cnt <= '0;
            else                     ext_cnt <= ext_cnt + EW'(1);
        end
    end

    assign tick_ext = ext_rise && (ext_cnt == EXT_LAST);

    // R10
    sys_tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (SYS_DIV > 1 && tick_sys) |=> !tick_sys);

    // R10
    ext_tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        tick_ext |=> !tick_ext);

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         split,
    input  logic         run,
    input  logic         tick_lo,
    input  logic         tick_hi,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] cnt_lo,
    output logic [W-1:0] cnt_hi,
    output logic [W-1:0] rld_lo,
    output logic [W-1:0] rld_hi,
    output wrap_t        wraps
);
    localparam logic [W-1:0] ALL1 = '1;

    logic [W-1:0] rld_v [2];
    logic [W-1:0] lo_q, hi_q;
    logic [W-1:0] lo_nxt, hi_nxt;
    logic         lo_we, hi_we;
    logic         lo_at_max, hi_at_max;
    logic         lo_step, hi_step;
    logic         lo_wrap, hi_wrap, lo_reload;

    genvar b;
    generate
        for (b = 0; b < 2; b++) begin : g_reload
            localparam logic [2:0] RA = 3'(int'(A_RLD_LO) + b);
            logic [W-1:0] rld_r;
            always_ff @(posedge clk) begin
                if (rst)                      rld_r <= '0;
                else if (wr_en && addr == RA) rld_r <= wr_data;
            end
            assign rld_v[b] = rld_r;
        end
    endgenerate

    assign lo_we     = wr_en && (addr == A_CNT_LO);
    assign hi_we     = wr_en && (addr == A_CNT_HI);
    assign lo_at_max = (lo_q == ALL1);
    assign hi_at_max = (hi_q == ALL1);

    always_comb begin
        lo_step   = tick_lo && (split || run);
        hi_step   = split ? (tick_hi && run) : (lo_step && lo_at_max);
        lo_wrap   = lo_step && lo_at_max;
        hi_wrap   = hi_step && hi_at_max;
        lo_reload = lo_wrap && (split || hi_at_max);

        if (lo_reload)    lo_nxt = rld_v[0];
        else if (lo_step) lo_nxt = lo_q + W'(1);
        else              lo_nxt = lo_q;

        if (hi_wrap)      hi_nxt = rld_v[1];
        else if (hi_step) hi_nxt = hi_q + W'(1);
        else              hi_nxt = hi_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            lo_q <= lo_we ? wr_data : lo_nxt;
            hi_q <= hi_we ? wr_data : hi_nxt;
        end
    end

    assign wraps.lo_wrap = lo_wrap && !lo_we;
    assign wraps.hi_wrap = hi_wrap && !hi_we && (split || !lo_we);

    assign cnt_lo = lo_q;
    assign cnt_hi = hi_q;
    assign rld_lo = rld_v[0];
    assign rld_hi = rld_v[1];

    // R4
    carry_hi_chk: assert property (@(posedge clk) disable iff (rst)
        (!split && run && tick_lo && lo_q == ALL1 && hi_q != ALL1 && !wr_en)
        |=> hi_q == $past(hi_q) + W'(1));

    // R5
    split_lo_free_chk: assert property (@(posedge clk) disable iff (rst)
        (split && !run && tick_lo && lo_q != ALL1 && !wr_en)
        |=> lo_q == $past(lo_q) + W'(1));

    // R6
    split_hi_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (split && !run && !wr_en) |=> $stable(hi_q));

    // R7
    halt16_chk: assert property (@(posedge clk) disable iff (rst)
        (!split && !run && !wr_en) |=> ($stable(lo_q) && $stable(hi_q)));

endmodule

// File: rtl/tmr_ctrl_regs.sv
module tmr_ctrl_regs
    import tmr_pkg::*;
#(
    parameter int unsigned W = BYTE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    input  wrap_t        wraps,
    input  logic         irq_enable,
    input  logic [W-1:0] cnt_lo,
    input  logic [W-1:0] cnt_hi,
    input  logic [W-1:0] rld_lo,
    input  logic [W-1:0] rld_hi,
    output ctrl_t        ctrl,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    ctrl_t ctrl_q, ctrl_nxt;
    logic  wr_ctrl;

    assign wr_ctrl = wr_en && (addr == A_CTRL);

    always_comb begin
        ctrl_nxt = ctrl_q;
        if (wr_ctrl) ctrl_nxt = byte_to_ctrl(wr_data[7:0]);
        ctrl_nxt.ovf_hi = ctrl_nxt.ovf_hi | wraps.hi_wrap;
        ctrl_nxt.ovf_lo = ctrl_nxt.ovf_lo | wraps.lo_wrap;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_nxt;
    end

    always_comb begin
        case (addr)
            A_CTRL:   rd_data = W'(ctrl_to_byte(ctrl_q));
            A_RLD_LO: rd_data = rld_lo;
            A_RLD_HI: rd_data = rld_hi;
            A_CNT_LO: rd_data = cnt_lo;
            A_CNT_HI: rd_data = cnt_hi;
            default:  rd_data = '0;
        endcase
    end

    assign irq  = irq_enable && (ctrl_q.ovf_hi || (ctrl_q.lo_irq_en && ctrl_q.ovf_lo));
    assign ctrl = ctrl_q;

    // R8
    hi_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ovf_hi && !wr_ctrl) |=> ctrl_q.ovf_hi);

    // R8
    lo_flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.ovf_lo && !wr_ctrl) |=> ctrl_q.ovf_lo);

    // R8
    hw_set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        wraps.lo_wrap |=> ctrl_q.ovf_lo);

    // R9
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_enable |-> !irq);

    // R2
    unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (addr == A_CTRL) |-> (rd_data[4] == 1'b0 && rd_data[1] == 1'b0));

endmodule

// File: rtl/split_reload_timer.sv
module split_reload_timer
    import tmr_pkg::*;
#(
    parameter int unsigned W        = BYTE_W,
    parameter int unsigned SYS_DIV  = 12,
    parameter int unsigned EXT_DIV  = 8,
    parameter int unsigned SYNC_LEN = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ext_clk,
    input  logic         lo_fast,
    input  logic         hi_fast,
    input  logic         irq_enable,
    input  logic         wr_en,
    input  logic [2:0]   addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] rd_data,
    output logic         irq
);
    logic         tick_sys, tick_ext, base_tick;
    logic         tick_lo, tick_hi;
    ctrl_t        ctrl;
    wrap_t        wraps;
    logic [W-1:0] cnt_lo, cnt_hi, rld_lo, rld_hi;

    tmr_tick_gen #(
        .SYS_DIV (SYS_DIV),
        .EXT_DIV (EXT_DIV),
        .SYNC_LEN(SYNC_LEN)
    ) i_tick (
        .clk     (clk),
        .rst     (rst),
        .ext_clk (ext_clk),
        .tick_sys(tick_sys),
        .tick_ext(tick_ext)
    );

    assign base_tick = ctrl.ext_sel ? tick_ext : tick_sys;
    assign tick_lo   = lo_fast ? 1'b1 : base_tick;
    assign tick_hi   = hi_fast ? 1'b1 : base_tick;

    tmr_count_core #(.W(W)) i_core (
        .clk    (clk),
        .rst    (rst),
        .split  (ctrl.split),
        .run    (ctrl.run),
        .tick_lo(tick_lo),
        .tick_hi(tick_hi),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_data(wr_data),
        .cnt_lo (cnt_lo),
        .cnt_hi (cnt_hi),
        .rld_lo (rld_lo),
        .rld_hi (rld_hi),
        .wraps  (wraps)
    );

    tmr_ctrl_regs #(.W(W)) i_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .wraps     (wraps),
        .irq_enable(irq_enable),
        .cnt_lo    (cnt_lo),
        .cnt_hi    (cnt_hi),
        .rld_lo    (rld_lo),
        .rld_hi    (rld_hi),
        .ctrl      (ctrl),
        .rd_data   (rd_data),
        .irq       (irq)
    );

endmodule

// File: tb/test_split_reload_timer.sv
module test_split_reload_timer;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ext_clk = 1'b0;
    logic       lo_fast = 1'b1;
    logic       hi_fast = 1'b1;
    logic       irq_enable = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq;

    typedef struct {
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;

    item_t sb_q[$];
    logic  probe = 1'b0;
    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    localparam int K_CTRL = 0, K_RLO = 1, K_RHI = 2, K_CLO = 3, K_CHI = 4, K_IRQ = 8;

    split_reload_timer i_split_reload_timer (
        .clk       (clk),
        .rst       (rst),
        .ext_clk   (ext_clk),
        .lo_fast   (lo_fast),
        .hi_fast   (hi_fast),
        .irq_enable(irq_enable),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .rd_data   (rd_data),
        .irq       (irq)
    );

    always #2 clk = ~clk;

    initial begin
        #1;
        forever #8 ext_clk = ~ext_clk;
    end

    // monitor: pops the expected item and compares against the ports
    always @(negedge clk) begin
        if (probe && sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = (it.kind == K_IRQ) ? {7'd0, irq} : rd_data;
            n_chk++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s kind=%0d actual=%02h expected=%02h", it.req, it.kind, act, it.exp);
            end
        end
    end

    task automatic expect_val(int kind, logic [7:0] exp, string req);
        item_t it;
        it.kind = kind;
        it.exp  = exp;
        it.req  = req;
        sb_q.push_back(it);
        if (kind != K_IRQ) addr = 3'(kind);
        probe = 1'b1;
        @(negedge clk);
        @(posedge clk);
        #1;
        probe = 1'b0;
    endtask

    task automatic wr(int a, logic [7:0] d);
        @(posedge clk);
        #1;
        wr_en   = 1'b1;
        addr    = 3'(a);
        wr_data = d;
        @(posedge clk);
        #1;
        wr_en = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_up();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_up();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;

        // R1 reset state
        expect_val(K_CTRL, 8'h00, "R1");
        expect_val(K_RLO,  8'h00, "R1");
        expect_val(K_RHI,  8'h00, "R1");
        expect_val(K_CLO,  8'h00, "R1");
        expect_val(K_CHI,  8'h00, "R1");
        expect_val(K_IRQ,  8'h00, "R1");

        // R2 unused control bits
        wr(K_CTRL, 8'h12);
        expect_val(K_CTRL, 8'h00, "R2");

        // R3 full 16-bit wrap with reload
        wr(K_RLO, 8'h34);
        wr(K_RHI, 8'h12);
        wr(K_CLO, 8'hFD);
        wr(K_CHI, 8'hFF);
        wr(K_CTRL, 8'h04);
        expect_val(K_CLO, 8'hFD, "R3");
        expect_val(K_CLO, 8'hFE, "R3");
        expect_val(K_CLO, 8'hFF, "R3");
        expect_val(K_CHI, 8'h12, "R3");
        expect_val(K_CLO, 8'h35, "R3");
        expect_val(K_CTRL, 8'hC4, "R3");
        expect_val(K_IRQ, 8'h00, "R9");
        irq_enable = 1'b1;
        expect_val(K_IRQ, 8'h01, "R9");
        idle(5);
        expect_val(K_CTRL, 8'hC4, "R8");
        wr(K_CTRL, 8'h00);
        expect_val(K_CTRL, 8'h00, "R8");

        // R7 halted in 16-bit mode
        wr(K_CLO, 8'h05);
        idle(5);
        expect_val(K_CLO, 8'h05, "R7");

        // R4 low wrap carries into high byte
        wr(K_CHI, 8'h00);
        wr(K_CLO, 8'hFF);
        wr(K_CTRL, 8'h04);
        expect_val(K_CTRL, 8'h04, "R4");
        expect_val(K_CHI, 8'h01, "R4");
        expect_val(K_CTRL, 8'h44, "R4");
        expect_val(K_IRQ, 8'h00, "R9");
        wr(K_CTRL, 8'h60);
        expect_val(K_IRQ, 8'h01, "R9");
        wr(K_CTRL, 8'h00);

        // R5 split low byte runs without run bit
        wr(K_RLO, 8'hF0);
        wr(K_RHI, 8'h80);
        wr(K_CHI, 8'hFF);
        wr(K_CLO, 8'hFE);
        wr(K_CTRL, 8'h08);
        expect_val(K_CLO, 8'hFE, "R5");
        expect_val(K_CLO, 8'hFF, "R5");
        expect_val(K_CLO, 8'hF0, "R5");
        expect_val(K_CTRL, 8'h48, "R5");
        expect_val(K_CHI, 8'hFF, "R6");

        // R6 split high byte with run
        wr(K_CTRL, 8'h0C);
        expect_val(K_CHI, 8'hFF, "R6");
        expect_val(K_CHI, 8'h80, "R6");
        expect_val(K_CTRL, 8'h8C, "R6");

        // R11 write wins over a step
        wr(K_CLO, 8'h40);
        expect_val(K_CLO, 8'h40, "R11");
        expect_val(K_CLO, 8'h41, "R11");

        // R8 hardware set against software clear in one cycle
        wr(K_CLO, 8'hFE);
        wr(K_CTRL, 8'h08);
        expect_val(K_CTRL, 8'h48, "R8");

        // R10 system divide-by-12 on the high byte
        hi_fast = 1'b0;
        wr(K_CTRL, 8'h0C);
        wr(K_CHI, 8'h00);
        idle(24);
        expect_val(K_CHI, 8'h02, "R10");

        // R10 external divide-by-8
        wr(K_CTRL, 8'h0D);
        wr(K_CHI, 8'h00);
        idle(64);
        expect_val(K_CHI, 8'h02, "R10");

        irq_enable = 1'b0;
        expect_val(K_IRQ, 8'h00, "R9");

        done = 1'b1;
        finish_up();
    end

endmodule